// File: doc/BRIEF.md
# Left Shifter with Exact Overflow Reporting

This block shifts a word left by a count from 0 to W-1 and returns the shifted word with a set of status flags. A plain shifter's carry shows only the last bit pushed out of the top. This unit also reports two overflow results that cover the whole shift. The unsigned overflow is set when any set bit was discarded. The signed overflow is set when the top count+1 bits of the operand are not all the same, which means the result no longer has the value or the sign it should have.

The zero, sign and parity flags come from the shifted word. For a single-place shift, every flag matches what an adder reports when the operand is added to itself. A request is accepted by raising `in_valid_i`. The result and all flags are registered and appear one cycle later with `out_valid_o`. Between requests, the registered data holds its last value.

Top module: `shl_ovf_unit`

## Requirements
- R1: `result_o` equals `operand_i` shifted left by `count_i` (0 to 31), with the upper bits dropped, so the value is modulo 2^32.
- R2: For a count n of 1 or more, `carry_o` is operand bit 32-n, which is the last bit to leave the top. For a count of 0 it is 0.
- R3: `uovf_o` is 1 exactly when at least one of the n most significant operand bits is 1. Example: 0xF0000000 with count 7 gives result 0, carry 0 and `uovf_o` 1. The operand 0x00000000 with count 7 gives the same result with `uovf_o` 0.
- R4: `sovf_o` is 1 exactly when the n+1 most significant operand bits are not all equal.
- R5: A count of 0 passes the operand through unchanged and clears `carry_o`, `uovf_o` and `sovf_o`.
- R6: The flags are taken from the result. `zero_o` is 1 when the result is all zeros. `sign_o` is result bit 31. `parity_o` is 1 when result bits 7:0 contain an even number of ones.
- R7: For a count of 1, `carry_o` equals `uovf_o`. The carry, `sovf_o`, zero, sign and parity flags all equal those of the 33-bit sum operand+operand. That sum's signed overflow is operand bit 31 XOR sum bit 31.
- R8: `out_valid_o` equals `in_valid_i` one cycle earlier. Result and flag registers load only when `in_valid_i` is 1 and otherwise hold.
- R9: While `rst_ni` is low, every output is 0.
- R10: `uovf_o` is 1 exactly when a logical right shift of the result by n differs from the operand. `sovf_o` is 1 exactly when an arithmetic right shift of the result by n differs from the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| operand_i | input | 32 | Value to shift |
| count_i | input | 5 | Shift distance |
| out_valid_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Last bit shifted out |
| uovf_o | output | 1 | Unsigned overflow |
| sovf_o | output | 1 | Signed overflow |
| zero_o | output | 1 | Result is zero |
| sign_o | output | 1 | Result bit 31 |
| parity_o | output | 1 | Even parity of the result's low byte |

## Verification
The properties relate each registered output to the operand and count seen one edge earlier through `$past`. They therefore assume that `in_valid_i`, `operand_i` and `count_i` carry known values on every edge once reset is released. The bench drives all three inputs with defined values from time zero. It changes them only on the falling clock edge, so every sampled value is settled and known.

// File: rtl/shl_pkg.sv
package shl_pkg;
  typedef struct packed {
    logic carry;
    logic uovf;
    logic sovf;
    logic zero;
    logic sign;
    logic parity;
  } shl_flags_t;
endpackage

// File: rtl/shl_barrel.sv
module shl_barrel #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [CW-1:0] count_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] stage [CW+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < CW; k++) begin : g_stage
    assign stage[k+1] = count_i[k] ? (stage[k] << (1 << k)) : stage[k];
  end

  assign data_o = stage[CW];
endmodule

// File: rtl/shl_ovf_detect.sv
module shl_ovf_detect #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [CW-1:0] count_i,
  output logic          carry_o,
  output logic          uovf_o,
  output logic          sovf_o
);
  logic [W-1:0]  mask_u;
  logic [W-1:0]  mask_s;
  logic [W-1:0]  top_s;
  logic [CW-1:0] out_idx;

  // top n bits set
  assign mask_u = ~({W{1'b1}} >> count_i);
  // top n+1 bits set
  assign mask_s = W'($signed({1'b1, {(W-1){1'b0}}}) >>> count_i);
  assign top_s  = data_i & mask_s;

  // W is a power of two, so 0-n wraps to W-n
  assign out_idx = '0 - count_i;

  assign carry_o = (count_i != '0) & data_i[out_idx];
  assign uovf_o  = |(data_i & mask_u);
  assign sovf_o  = (top_s != '0) && (top_s != mask_s);
endmodule

// File: rtl/shl_flag_gen.sv
module shl_flag_gen #(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  output logic         zero_o,
  output logic         sign_o,
  output logic         parity_o
);
  assign zero_o   = ~|res_i;
  assign sign_o   = res_i[W-1];
  assign parity_o = ~^res_i[7:0];
endmodule

// File: rtl/shl_ovf_unit.sv
module shl_ovf_unit
  import shl_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [W-1:0]  operand_i,
  input  logic [CW-1:0] count_i,
  output logic          out_valid_o,
  output logic [W-1:0]  result_o,
  output logic          carry_o,
  output logic          uovf_o,
  output logic          sovf_o,
  output logic          zero_o,
  output logic          sign_o,
  output logic          parity_o
);
  logic [W-1:0] res_d;
  shl_flags_t   flg_d, flg_q;

  shl_barrel #(.W(W), .CW(CW)) u_barrel (
    .data_i  (operand_i),
    .count_i (count_i),
    .data_o  (res_d)
  );

  shl_ovf_detect #(.W(W), .CW(CW)) u_ovf (
    .data_i  (operand_i),
    .count_i (count_i),
    .carry_o (flg_d.carry),
    .uovf_o  (flg_d.uovf),
    .sovf_o  (flg_d.sovf)
  );

  shl_flag_gen #(.W(W)) u_flags (
    .res_i    (res_d),
    .zero_o   (flg_d.zero),
    .sign_o   (flg_d.sign),
    .parity_o (flg_d.parity)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      flg_q       <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o <= res_d;
        flg_q    <= flg_d;
      end
    end
  end

  assign carry_o  = flg_q.carry;
  assign uovf_o   = flg_q.uovf;
  assign sovf_o   = flg_q.sovf;
  assign zero_o   = flg_q.zero;
  assign sign_o   = flg_q.sign;
  assign parity_o = flg_q.parity;
endmodule

// File: rtl/shl_ovf_chk.sv
module shl_ovf_chk #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic [W-1:0]  operand_i,
  input logic [CW-1:0] count_i,
  input logic          out_valid_o,
  input logic [W-1:0]  result_o,
  input logic          carry_o,
  input logic          uovf_o,
  input logic          sovf_o,
  input logic          zero_o,
  input logic          sign_o,
  input logic          parity_o
);
  p_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> result_o == ($past(operand_i) << $past(count_i)));

  p_ushift_back_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> uovf_o == ((result_o >> $past(count_i)) != $past(operand_i)));

  p_sshift_back_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> sovf_o == (($signed(result_o) >>> $past(count_i)) != $signed($past(operand_i))));

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && count_i == '0) |=> (!carry_o && !uovf_o && !sovf_o && result_o == $past(operand_i)));

  p_single_carry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && count_i == CW'(1)) |=> (carry_o == uovf_o && sovf_o == (result_o[W-1] ^ $past(operand_i[W-1]))));

  p_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(result_o) && $stable(uovf_o) && $stable(sovf_o) && $stable(carry_o)));

  p_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (zero_o == (result_o == '0) && sign_o == result_o[W-1] && parity_o == ~^result_o[7:0]));

  always_comb begin
    if (!rst_ni) begin
      a_reset_r9: assert (out_valid_o == 1'b0 || $isunknown(out_valid_o));
    end
  end
endmodule

bind shl_ovf_unit shl_ovf_chk #(.W(W), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .operand_i   (operand_i),
  .count_i     (count_i),
  .out_valid_o (out_valid_o),
  .result_o    (result_o),
  .carry_o     (carry_o),
  .uovf_o      (uovf_o),
  .sovf_o      (sovf_o),
  .zero_o      (zero_o),
  .sign_o      (sign_o),
  .parity_o    (parity_o)
);

// File: tb/sim_shl_ovf_unit.sv
module sim_shl_ovf_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [4:0]  count = '0;
  logic        out_valid, carry, uovf, sovf, zero, sign, parity;
  logic [31:0] result;
  int          n_run = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  shl_ovf_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .operand_i(operand),
    .count_i(count), .out_valid_o(out_valid), .result_o(result), .carry_o(carry),
    .uovf_o(uovf), .sovf_o(sovf), .zero_o(zero), .sign_o(sign), .parity_o(parity)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  // issue one request and check every output against the requirement model
  task automatic apply(input logic [31:0] op, input logic [4:0] n);
    logic [63:0] wu, ws;
    logic [31:0] er;
    logic        ec, eu, es;
    wu = {32'b0, op} << n;
    ws = {{32{op[31]}}, op} << n;
    er = wu[31:0];
    ec = (n != 0) ? wu[32] : 1'b0;
    eu = (wu[63:32] != 0);
    es = !((ws[63:31] == '0) || (&ws[63:31]));
    @(negedge clk);
    operand = op; count = n; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R8 valid", {31'b0, out_valid}, 32'd1);
    chk(result == er, "R1 result", result, er);
    chk(carry == ec, "R2 carry", {31'b0, carry}, {31'b0, ec});
    chk(uovf == eu, "R3 uovf", {31'b0, uovf}, {31'b0, eu});
    chk(sovf == es, "R4 sovf", {31'b0, sovf}, {31'b0, es});
    chk(uovf == ((er >> n) != op), "R10 unsigned back", {31'b0, uovf}, {31'b0, eu});
    chk(sovf == (($signed(er) >>> n) != $signed(op)), "R10 signed back", {31'b0, sovf}, {31'b0, es});
    chk(zero == (er == 0), "R6 zero", {31'b0, zero}, {31'b0, er == 0});
    chk(sign == er[31], "R6 sign", {31'b0, sign}, {31'b0, er[31]});
    chk(parity == ~^er[7:0], "R6 parity", {31'b0, parity}, {31'b0, ~^er[7:0]});
  endtask

  task automatic t_reset();
    #5;
    chk(out_valid == 0, "R9 out_valid", {31'b0, out_valid}, 0);
    chk(result == 0, "R9 result", result, 0);
    chk({carry, uovf, sovf, zero, sign, parity} == 0, "R9 flags",
        {26'b0, carry, uovf, sovf, zero, sign, parity}, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_lost_bits();
    apply(32'hF000_0000, 5'd7);
    chk(result == 0 && !carry && uovf, "R3 F0000000<<7", {29'b0, carry, uovf, result == 0}, 32'd3);
    apply(32'h0000_0000, 5'd7);
    chk(result == 0 && !uovf && !sovf, "R3 zero<<7", {30'b0, uovf, sovf}, 0);
    apply(32'hFE00_0001, 5'd6);   // top 7 all ones: no signed ovf
    chk(!sovf && uovf, "R4 uniform top", {30'b0, uovf, sovf}, 32'd2);
  endtask

  task automatic t_count_zero();
    apply(32'hDEAD_BEEF, 5'd0);
    chk(result == 32'hDEAD_BEEF && !carry && !uovf && !sovf, "R5 passthrough",
        result, 32'hDEAD_BEEF);
  endtask

  task automatic t_count_one();
    logic [31:0] ops [4] = '{32'h8000_0000, 32'h4000_0001, 32'hC000_00FF, 32'h1234_5678};
    foreach (ops[i]) begin
      logic [32:0] s;
      s = {1'b0, ops[i]} + {1'b0, ops[i]};
      apply(ops[i], 5'd1);
      chk(carry == uovf && carry == s[32], "R7 carry", {31'b0, carry}, {31'b0, s[32]});
      chk(sovf == (ops[i][31] ^ s[31]), "R7 sovf", {31'b0, sovf}, {31'b0, ops[i][31] ^ s[31]});
      chk(zero == (s[31:0] == 0) && sign == s[31] && parity == ~^s[7:0], "R7 zsp",
          {29'b0, zero, sign, parity}, {29'b0, s[31:0] == 0, s[31], ~^s[7:0]});
    end
  endtask

  task automatic t_sweep();
    logic [31:0] pats [4] = '{32'h0000_0001, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h7FFF_FFFF};
    foreach (pats[i])
      for (int n = 0; n < 32; n += 3) apply(pats[i], 5'(n));
    apply(32'h0000_0001, 5'd31);
    apply(32'h8000_0000, 5'd31);
  endtask

  task automatic t_hold();
    logic [31:0] r0;
    logic        u0v;
    apply(32'hF000_0000, 5'd4);
    r0 = result; u0v = uovf;
    operand = 32'h0000_0001; count = 5'd2;
    @(negedge clk);
    chk(out_valid == 0, "R8 idle valid", {31'b0, out_valid}, 0);
    chk(result == r0 && uovf == u0v, "R8 hold", result, r0);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog act=0x%08h exp=0x%08h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_lost_bits();
    t_count_zero();
    t_count_one();
    t_sweep();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule